// File: doc/BRIEF.md
# Banked Interrupt-Level Register File

This block holds the working registers of a small communications processor. Every interrupt priority level gets a private set of eight registers, so taking an interrupt only means changing the level input; no registers have to be saved. Register 0 of each set is the program counter and registers 1 to 7 are accumulators. The odd accumulators can also be reached as two independent byte registers each.

Four physical banks back five levels. The background level and three interrupt levels own one bank each. A rarely used error level has no bank of its own and works in the bank of the next-higher-priority level, so both levels see the same registers. A level-to-bank table parameter holds this mapping. The file has two combinational read ports and one write port. A separate increment strobe advances the current program counter.

Top module: `bank_regfile`

## Requirements
- R1: While rst_ni is low, every register of every bank is cleared to zero, and all reads return zero after reset.
- R2: A word write (spec 0 to 7 selects register 0 to 7) stores the full wdata_i into the register of the current level's bank, and a later read with the same spec at that level returns it.
- R3: Levels 0, 1, 2 and 3 select banks 0, 1, 2 and 3. A write or increment at one level leaves every other bank unchanged.
- R4: Level 4 (error) selects bank 1, so a write made at level 1 or level 4 is read back at the other. Levels 5 to 7 select bank 0.
- R5: Specs 8 to 15 are byte registers. Byte index b = spec-8 names odd register 2*(b/2)+1. Even b is bits 15:8 and odd b is bits 7:0. A byte write copies wdata_i[7:0] into that lane and leaves all other bits of the register unchanged.
- R6: A byte read returns the selected byte zero-extended to the register width.
- R7: Reads are combinational. A read made in the same cycle as a write or an increment to that register returns the value the register will hold after the clock edge.
- R8: pc_inc_i adds one to register 0 of the current level's bank, wrapping modulo 2^W.
- R9: A word write to register 0 in the same cycle as pc_inc_i stores wdata_i and drops the increment. A write to another register in that cycle happens together with the increment.
- R10: The two read ports decode and return their specs independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| level_i | input | 3 | Current interrupt level |
| rs_a_i | input | 4 | Read port A register spec |
| rd_a_o | output | W | Read port A data |
| rs_b_i | input | 4 | Read port B register spec |
| rd_b_o | output | W | Read port B data |
| we_i | input | 1 | Write enable |
| wspec_i | input | 4 | Write register spec |
| wdata_i | input | W | Write data (byte writes use bits 7:0) |
| pc_inc_i | input | 1 | Increment register 0 of the current bank |

## Verification
The bench writes a different value into every register of every bank, then reads them all back at each level. A bank decoder that shared or crossed banks would return another level's data. It checks the alias both ways through level 4 and bank 0 through the unused levels; a design that gave the error level its own bank, or sent it to the wrong neighbour, would miss the partner's values. Byte writes carry junk in the upper write-data bits and target both lanes of several odd registers. A design that merged the wrong lane, used the wrong source bits or failed to zero-extend would show it on the word and byte reads. The bench also samples reads before the edge of a write or an increment, runs the program counter through its wrap, and collides a register-0 write with an increment; a design missing the bypass or the write priority would return stale or incremented values.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;
  localparam int unsigned NREG   = 8;
  localparam int unsigned SPEC_W = 4;
  localparam int unsigned LVL_W  = 3;
  localparam int unsigned IDX_W  = $clog2(NREG);

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             is_byte;
    logic             hi;
  } spec_t;

  // byte spec b -> odd reg {b[2:1],1}; even b = high lane
  function automatic spec_t spec_decode(input logic [SPEC_W-1:0] s);
    spec_t r;
    r.is_byte = s[SPEC_W-1];
    r.hi      = s[SPEC_W-1] & ~s[0];
    r.idx     = s[SPEC_W-1] ? {s[2:1], 1'b1} : s[IDX_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/bank_regfile_lvl_map.sv
module bank_regfile_lvl_map
  import bank_regfile_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned NL = 5,
  parameter int unsigned BW = 2,
  parameter int LVL_BANK [NL] = '{0, 1, 2, 3, 1}
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [BW-1:0]    bank_o
);
  // unmapped levels fall to bank 0
  always_comb begin
    bank_o = '0;
    for (int l = 0; l < NL; l++) begin
      if (level_i == LVL_W'(l)) bank_o = BW'(LVL_BANK[l]);
    end
  end
endmodule

// File: rtl/bank_regfile_bank.sv
module bank_regfile_bank
  import bank_regfile_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned BW = 2,
  parameter int unsigned ID = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [BW-1:0]            bank_i,
  input  logic                     we_i,
  input  spec_t                    spec_i,
  input  logic [W-1:0]             wdata_i,
  input  logic                     inc_i,
  output logic [NREG-1:0][W-1:0]   q_o,
  output logic [NREG-1:0][W-1:0]   d_o
);
  logic sel;
  assign sel = (bank_i == BW'(ID));

  always_comb begin
    d_o = q_o;
    if (sel) begin
      if (inc_i) d_o[0] = q_o[0] + W'(1);
      if (we_i) begin
        if (!spec_i.is_byte)  d_o[spec_i.idx]       = wdata_i;
        else if (spec_i.hi)   d_o[spec_i.idx][15:8] = wdata_i[7:0];
        else                  d_o[spec_i.idx][7:0]  = wdata_i[7:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else if (sel) q_o <= d_o;
  end
endmodule

// File: rtl/bank_regfile_rd_port.sv
module bank_regfile_rd_port
  import bank_regfile_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [SPEC_W-1:0]      spec_i,
  input  logic [NREG-1:0][W-1:0] regs_i,
  output logic [W-1:0]           rdata_o
);
  spec_t        s;
  logic [W-1:0] word;
  logic [7:0]   lane;

  assign s    = spec_decode(spec_i);
  assign word = regs_i[s.idx];
  assign lane = s.hi ? word[15:8] : word[7:0];

  always_comb begin
    if (s.is_byte) rdata_o = {{(W-8){1'b0}}, lane};
    else           rdata_o = word;
  end
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned NB = 4,
  parameter int unsigned NL = 5,
  parameter int LVL_BANK [NL] = '{0, 1, 2, 3, 1}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        level_i,
  input  logic [3:0]        rs_a_i,
  output logic [W-1:0]      rd_a_o,
  input  logic [3:0]        rs_b_i,
  output logic [W-1:0]      rd_b_o,
  input  logic              we_i,
  input  logic [3:0]        wspec_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              pc_inc_i
);
  localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1;

  logic [BW-1:0]                      bsel;
  spec_t                              wspec;
  logic [NB-1:0][NREG-1:0][W-1:0]     bank_q;
  logic [NB-1:0][NREG-1:0][W-1:0]     bank_d;
  logic [NREG-1:0][W-1:0]             cur_d;

  assign wspec = spec_decode(wspec_i);

  bank_regfile_lvl_map #(.NB(NB), .NL(NL), .BW(BW), .LVL_BANK(LVL_BANK)) u_map (
    .level_i (level_i),
    .bank_o  (bsel)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bank_regfile_bank #(.W(W), .BW(BW), .ID(b)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .bank_i  (bsel),
      .we_i    (we_i),
      .spec_i  (wspec),
      .wdata_i (wdata_i),
      .inc_i   (pc_inc_i),
      .q_o     (bank_q[b]),
      .d_o     (bank_d[b])
    );
  end

  // next-state view of the current bank gives write-through reads
  assign cur_d = bank_d[bsel];

  bank_regfile_rd_port #(.W(W)) u_rd_a (
    .spec_i  (rs_a_i),
    .regs_i  (cur_d),
    .rdata_o (rd_a_o)
  );

  bank_regfile_rd_port #(.W(W)) u_rd_b (
    .spec_i  (rs_b_i),
    .regs_i  (cur_d),
    .rdata_o (rd_b_o)
  );
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned NB = 4,
  parameter int unsigned BW = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [BW-1:0]                bsel,
  input logic                         we_i,
  input logic [3:0]                   wspec_i,
  input logic [W-1:0]                 wdata_i,
  input logic                         pc_inc_i,
  input logic [3:0]                   rs_a_i,
  input logic [W-1:0]                 rd_a_o,
  input logic [NB-1:0][7:0][W-1:0]    bank_q
);
  // R2
  word_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wspec_i[3]) |=>
      (bank_q[$past(bsel)][$past(wspec_i[2:0])] == $past(wdata_i)));

  // R5
  byte_hi_keeps_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wspec_i[3] && !wspec_i[0]) |=>
      (bank_q[$past(bsel)][{$past(wspec_i[2:1]), 1'b1}][7:0] ==
       $past(bank_q[bsel][{wspec_i[2:1], 1'b1}][7:0])));

  // R5
  byte_lo_keeps_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wspec_i[3] && wspec_i[0]) |=>
      (bank_q[$past(bsel)][{$past(wspec_i[2:1]), 1'b1}][W-1:8] ==
       $past(bank_q[bsel][{wspec_i[2:1], 1'b1}][W-1:8])));

  // R8
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_inc_i && !(we_i && wspec_i == 4'd0)) |=>
      (bank_q[$past(bsel)][0] == $past(bank_q[bsel][0]) + W'(1)));

  // R6
  byte_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_a_i[3] |-> (rd_a_o[W-1:8] == '0));

  for (genvar k = 0; k < NB; k++) begin : g_iso
    // R3
    bank_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bsel != BW'(k)) |=> (bank_q[k] == $past(bank_q[k])));
  end
endmodule

bind bank_regfile bank_regfile_chk #(.W(W), .NB(NB), .BW(BW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bsel     (bsel),
  .we_i     (we_i),
  .wspec_i  (wspec_i),
  .wdata_i  (wdata_i),
  .pc_inc_i (pc_inc_i),
  .rs_a_i   (rs_a_i),
  .rd_a_o   (rd_a_o),
  .bank_q   (bank_q)
);

// File: tb/bank_regfile_test.sv
`timescale 1ns/1ps
module bank_regfile_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [2:0]  level_i = 0;
  logic [3:0]  rs_a_i = 0, rs_b_i = 0, wspec_i = 0;
  logic [15:0] rd_a_o, rd_b_o, wdata_i = 0;
  logic        we_i = 0, pc_inc_i = 0;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m [4][8];

  always #5 clk_i = ~clk_i;

  bank_regfile uut (.*);

  function automatic int bmap(input logic [2:0] l);
    case (l)
      3'd0: return 0; 3'd1: return 1; 3'd2: return 2;
      3'd3: return 3; 3'd4: return 1; default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] mrd(input logic [2:0] l, input logic [3:0] s);
    logic [15:0] w;
    if (!s[3]) return m[bmap(l)][s[2:0]];
    w = m[bmap(l)][{s[2:1], 1'b1}];
    return s[0] ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic mclr();
    for (int b = 0; b < 4; b++) for (int r = 0; r < 8; r++) m[b][r] = 16'h0;
  endtask

  // model step: increment first, write overrides
  task automatic mstep(input logic [2:0] l, input logic we, input logic [3:0] s,
                       input logic [15:0] d, input logic inc);
    int b = bmap(l);
    if (inc) m[b][0] = m[b][0] + 16'd1;
    if (we) begin
      if (!s[3]) m[b][s[2:0]] = d;
      else if (!s[0]) m[b][{s[2:1], 1'b1}][15:8] = d[7:0];
      else m[b][{s[2:1], 1'b1}][7:0] = d[7:0];
    end
  endtask

  task automatic cyc(input logic [2:0] l, input logic we, input logic [3:0] s,
                     input logic [15:0] d, input logic inc);
    level_i = l; we_i = we; wspec_i = s; wdata_i = d; pc_inc_i = inc;
    @(posedge clk_i); #1;
    we_i = 0; pc_inc_i = 0;
    mstep(l, we, s, d, inc);
  endtask

  task automatic rd(input string tag, input logic [2:0] l, input logic [3:0] s);
    level_i = l; rs_a_i = s; rs_b_i = s; #1;
    chk({tag, " portA"}, rd_a_o, mrd(l, s));
    chk({tag, " portB"}, rd_b_o, mrd(l, s));
  endtask

  task automatic t_reset_state(input string tag);
    for (int l = 0; l < 8; l++)
      for (int s = 0; s < 16; s++) begin
        level_i = 3'(l); rs_a_i = 4'(s); #1;
        chk(tag, rd_a_o, 16'h0000);
      end
  endtask

  task automatic t_word_banks();
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < 8; r++)
        cyc(3'(l), 1, 4'(r), 16'(l * 16'h1000 + r * 16'h0111 + 1), 0);
    for (int l = 0; l < 4; l++)
      for (int r = 0; r < 8; r++) rd("R2 R3 word per bank", 3'(l), 4'(r));
  endtask

  task automatic t_alias();
    for (int r = 0; r < 8; r++) rd("R4 level4 sees bank1", 3'd4, 4'(r));
    cyc(3'd4, 1, 4'd3, 16'hBEEF, 0);
    rd("R4 level4 write seen at level1", 3'd1, 4'd3);
    cyc(3'd1, 1, 4'd5, 16'h7A11, 0);
    rd("R4 level1 write seen at level4", 3'd4, 4'd5);
    rd("R3 bank2 untouched by alias", 3'd2, 4'd3);
    for (int l = 5; l < 8; l++) rd("R4 levels 5-7 use bank0", 3'(l), 4'd2);
  endtask

  task automatic t_bytes();
    cyc(3'd2, 1, 4'd8,  16'hFFA5, 0);
    rd("R5 hi lane of r1", 3'd2, 4'd1);
    cyc(3'd2, 1, 4'd9,  16'hEE3C, 0);
    rd("R5 lo lane of r1", 3'd2, 4'd1);
    cyc(3'd2, 1, 4'd15, 16'h1177, 0);
    rd("R5 lo lane of r7", 3'd2, 4'd7);
    cyc(3'd2, 1, 4'd12, 16'h22C4, 0);
    rd("R5 hi lane of r5", 3'd2, 4'd5);
    for (int s = 8; s < 16; s++) rd("R6 byte read zero-extended", 3'd2, 4'(s));
    rd("R5 even reg r4 untouched", 3'd2, 4'd4);
    rd("R5 other bank untouched", 3'd3, 4'd1);
  endtask

  task automatic t_bypass();
    logic [15:0] exp;
    level_i = 3'd3; we_i = 1; wspec_i = 4'd4; wdata_i = 16'h5A5A; rs_a_i = 4'd4; #1;
    chk("R7 word write bypass", rd_a_o, 16'h5A5A);
    @(posedge clk_i); #1; we_i = 0; mstep(3'd3, 1, 4'd4, 16'h5A5A, 0);
    exp = {8'h9D, m[3][3][7:0]};
    we_i = 1; wspec_i = 4'd10; wdata_i = 16'h009D; rs_a_i = 4'd3; rs_b_i = 4'd10; #1;
    chk("R7 byte write bypass word", rd_a_o, exp);
    chk("R7 byte write bypass byte", rd_b_o, 16'h009D);
    @(posedge clk_i); #1; we_i = 0; mstep(3'd3, 1, 4'd10, 16'h009D, 0);
    exp = m[3][0] + 16'd1;
    pc_inc_i = 1; rs_a_i = 4'd0; #1;
    chk("R7 increment bypass", rd_a_o, exp);
    @(posedge clk_i); #1; pc_inc_i = 0; mstep(3'd3, 0, 0, 0, 1);
    rd("R7 value held after edge", 3'd3, 4'd0);
  endtask

  task automatic t_pc();
    cyc(3'd0, 1, 4'd0, 16'hFFFE, 0);
    cyc(3'd0, 0, 4'd0, 16'h0, 1);
    rd("R8 pc increments", 3'd0, 4'd0);
    cyc(3'd0, 0, 4'd0, 16'h0, 1);
    rd("R8 pc wraps to zero", 3'd0, 4'd0);
    cyc(3'd2, 0, 4'd0, 16'h0, 1);
    rd("R8 inc at level2 leaves bank0", 3'd0, 4'd0);
    rd("R8 inc at level2", 3'd2, 4'd0);
    cyc(3'd0, 1, 4'd0, 16'h1234, 1);
    rd("R9 write beats increment", 3'd0, 4'd0);
    cyc(3'd0, 1, 4'd6, 16'hC0DE, 1);
    rd("R9 pc increments with other write", 3'd0, 4'd0);
    rd("R9 other write lands", 3'd0, 4'd6);
  endtask

  task automatic t_ports();
    level_i = 3'd1; rs_a_i = 4'd5; rs_b_i = 4'd11; #1;
    chk("R10 port A word", rd_a_o, mrd(3'd1, 4'd5));
    chk("R10 port B byte", rd_b_o, mrd(3'd1, 4'd11));
    rs_a_i = 4'd14; rs_b_i = 4'd0; #1;
    chk("R10 port A byte", rd_a_o, mrd(3'd1, 4'd14));
    chk("R10 port B word", rd_b_o, mrd(3'd1, 4'd0));
  endtask

  task automatic t_reset_again();
    @(negedge clk_i); rst_ni = 0; #1;
    mclr();
    t_reset_state("R1 async clear after data");
    @(negedge clk_i); rst_ni = 1;
  endtask

  bit done = 0;

  initial begin
    mclr();
    repeat (3) @(posedge clk_i);
    #1; t_reset_state("R1 reset state");
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1;
    t_reset_state("R1 reads zero after reset");
    t_word_banks();
    t_alias();
    t_bytes();
    t_bypass();
    t_pc();
    t_ports();
    t_reset_again();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule